// File: doc/BRIEF.md
# Strided Matrix Block Address Generator

This block sequences the memory side of a two-dimensional block transfer for a lane-parallel matrix unit. A scalar front end hands it one load or store request in a single transfer. The request carries a base byte address, a row pitch in bytes, a row count and a strip width. The generator then walks the block one row per clock. Each row becomes one memory request that moves a whole strip of up to `LANES` contiguous elements. For a load, the data lands in a load data queue. For a store, the data comes from a store data queue.

The row address is kept in an accumulator that adds the pitch after every issued row, so no multiplier is needed. Issue pauses in any cycle in which the target queue cannot take part: a full load queue for loads, or an empty store queue for stores. The row counter and the address hold through the pause. A new request is taken only while the generator is idle. A single-cycle completion pulse marks the end of the block.

Top module: `mblk_agen`

## Requirements
- R1: After reset `busy`, `done` and `mem_valid` are 0 and `req_ready` is 1.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1; `req_ready` is 0 while busy, and a request presented while busy leaves the addresses and the row count of the running block unchanged.
- R3: `busy` rises in the cycle after acceptance, and the first issued row address equals the accepted base.
- R4: The k-th issued row (k counting from 0) has address base + k × pitch modulo 2^ADDR_W, so a pitch with the top bit set walks downward.
- R5: Exactly `req_rows_m1`+1 rows are issued per request (1 to 1024 with the 10-bit field), at most one per cycle.
- R6: A load (`req_store`=0) issues no row in a cycle with `ldq_full`=1, keeps its address and count through that cycle, and ignores `sdq_empty`.
- R7: A store (`req_store`=1) issues no row in a cycle with `sdq_empty`=1, ignores `ldq_full`, and drives `mem_write`=1; loads drive `mem_write`=0.
- R8: `mem_be` has its low (`req_width_m1`+1)×ELEM_BYTES bits set and all other bits clear (strip width 1 to LANES elements).
- R9: `done` is 1 for exactly one cycle, the cycle after the last row is issued. `busy` is 0 in that same cycle, and `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered by the scalar front end |
| req_ready | output | 1 | Generator idle, request can be taken |
| req_store | input | 1 | 1 = store block, 0 = load block |
| req_base | input | ADDR_W | Byte address of the first row |
| req_pitch | input | ADDR_W | Byte distance between consecutive rows |
| req_rows_m1 | input | ROW_W | Row count minus one |
| req_width_m1 | input | LANE_W | Elements per row minus one |
| ldq_full | input | 1 | Load data queue cannot accept a row |
| sdq_empty | input | 1 | Store data queue has no row to give |
| mem_valid | output | 1 | Row request issued this cycle |
| mem_write | output | 1 | Issued row is a store |
| mem_addr | output | ADDR_W | Byte address of the current row |
| mem_be | output | LANES×ELEM_BYTES | Byte enables of the row |
| busy | output | 1 | Block transfer in progress |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
The bench targets the single-row block, because a counter that tests for completion one step late would issue a second row. It also targets the full 1024-row block, where a narrow counter would wrap and never finish. Random queue back-pressure checks that a stalled cycle neither advances the address nor loses a row. The bench also toggles the queue flag that does not apply to the current direction, which exposes a design that stalls on the wrong queue. A zero pitch and a wrapping negative pitch show whether the accumulator adds the stored pitch, and a second request offered mid-block shows whether the running block is ever overwritten.

// File: rtl/mblk_agen_pkg.sv
package mblk_agen_pkg;
   typedef enum logic {
      DIR_LOAD  = 1'b0,
      DIR_STORE = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/mblk_row_ctr.sv
module mblk_row_ctr #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ROW_W-1:0] load_rows_m1,
   input  logic             step,
   output logic             busy,
   output logic             last
);
   logic [ROW_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
         busy     <= 1'b0;
      end else if (load) begin
         remain_q <= load_rows_m1;
         busy     <= 1'b1;
      end else if (step) begin
         if (last) busy <= 1'b0;
         else      remain_q <= remain_q - 1'b1;
      end
   end

   assign last = (remain_q == '0);

   // R2: the count only changes by loading while idle or stepping
   assert_load_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);
   assert_hold_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !step |=> remain_q == $past(remain_q));
endmodule

// File: rtl/mblk_addr_acc.sv
module mblk_addr_acc #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_base,
   input  logic [ADDR_W-1:0] load_pitch,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] pitch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr    <= '0;
         pitch_q <= '0;
      end else if (load) begin
         addr    <= load_base;
         pitch_q <= load_pitch;
      end else if (step) begin
         addr    <= addr + pitch_q;
      end
   end

   // R4: each issued row moves the address by the stored pitch
   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load |=> addr == $past(addr) + $past(pitch_q));
endmodule

// File: rtl/mblk_be_gen.sv
module mblk_be_gen #(
   parameter int LANES      = 4,
   parameter int ELEM_BYTES = 4,
   parameter int LANE_W     = $clog2(LANES),
   parameter int BE_W       = LANES * ELEM_BYTES
) (
   input  logic [LANE_W-1:0] width_m1,
   output logic [BE_W-1:0]   be
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign be[l*ELEM_BYTES +: ELEM_BYTES] =
         {ELEM_BYTES{(LANE_W'(l) <= width_m1)}};
   end

   // R8: mask is a contiguous run from bit 0
   always_comb begin
      assert_be_shape_R8: assert ($onehot0(be + 1'b1) && be[ELEM_BYTES-1:0] == '1);
   end
endmodule

// File: rtl/mblk_agen.sv
module mblk_agen
   import mblk_agen_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LANES      = 4,
   parameter int ELEM_BYTES = 4,
   parameter int MAX_ROWS   = 1024,
   parameter int ROW_W      = $clog2(MAX_ROWS),
   parameter int LANE_W     = $clog2(LANES),
   parameter int BE_W       = LANES * ELEM_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_pitch,
   input  logic [ROW_W-1:0]  req_rows_m1,
   input  logic [LANE_W-1:0] req_width_m1,
   input  logic              ldq_full,
   input  logic              sdq_empty,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BE_W-1:0]   mem_be,
   output logic              busy,
   output logic              done
);
   if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if ((1 << ROW_W) != MAX_ROWS) begin : g_bad_rows
      $error("MAX_ROWS must be a power of two");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   xfer_dir_e         dir_q;
   logic [LANE_W-1:0] width_q;
   logic              accept, stall, issue, last_row, done_q;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign stall     = (dir_q == DIR_STORE) ? sdq_empty : ldq_full;
   assign issue     = busy && !stall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q   <= DIR_LOAD;
         width_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= issue && last_row;
         if (accept) begin
            dir_q   <= req_store ? DIR_STORE : DIR_LOAD;
            width_q <= req_width_m1;
         end
      end
   end

   mblk_row_ctr #(.ROW_W(ROW_W)) i_rows (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_rows_m1(req_rows_m1),
      .step(issue), .busy(busy), .last(last_row)
   );

   mblk_addr_acc #(.ADDR_W(ADDR_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_base(req_base),
      .load_pitch(req_pitch), .step(issue), .addr(mem_addr)
   );

   mblk_be_gen #(.LANES(LANES), .ELEM_BYTES(ELEM_BYTES), .LANE_W(LANE_W), .BE_W(BE_W)) i_be (
      .width_m1(width_q), .be(mem_be)
   );

   assign mem_valid = issue;
   assign mem_write = (dir_q == DIR_STORE);
   assign done      = done_q;

   assert_valid_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> busy);
   assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> mem_addr == $past(req_base));
   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_valid |=> busy && mem_addr == $past(mem_addr));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_valid) && !busy);
endmodule

// File: tb/test_mblk_agen.sv
`timescale 1ns/1ps
module test_mblk_agen;
   localparam int AW = 32, RW = 10, LW = 2, BW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_store = 0, ldq_full = 0, sdq_empty = 0;
   logic [AW-1:0] req_base = '0, req_pitch = '0;
   logic [RW-1:0] req_rows_m1 = '0;
   logic [LW-1:0] req_width_m1 = '0;
   logic req_ready, mem_valid, mem_write, busy, done;
   logic [AW-1:0] mem_addr;
   logic [BW-1:0] mem_be;

   int checks = 0, fails = 0, cycles = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   mblk_agen i_mblk_agen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_store(req_store), .req_base(req_base), .req_pitch(req_pitch),
      .req_rows_m1(req_rows_m1), .req_width_m1(req_width_m1),
      .ldq_full(ldq_full), .sdq_empty(sdq_empty), .mem_valid(mem_valid),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
      .busy(busy), .done(done)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] exp_be(input int w_m1);
      return BW'((64'd1 << (4 * (w_m1 + 1))) - 1);
   endfunction

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [AW-1:0] p, input int k);
      return b + AW'(k) * p;
   endfunction

   // stall_pct: chance of the relevant queue blocking; inject: offer a rival request mid-block
   task automatic run_block(input bit st, input logic [AW-1:0] b, input logic [AW-1:0] p,
                            input int rows_m1, input int w_m1, input int stall_pct, input bit inject);
      int k = 0, guard = 0;
      bit injected = 0;
      @(negedge clk);
      check("R2 ready when idle", req_ready, 1);
      req_valid = 1; req_store = st; req_base = b; req_pitch = p;
      req_rows_m1 = RW'(rows_m1); req_width_m1 = LW'(w_m1);
      @(negedge clk);
      req_valid = 0;
      check("R3 busy after accept", busy, 1);
      check("R2 not ready while busy", req_ready, 0);
      while (k <= rows_m1 && guard < 20000) begin
         bit blk = ($urandom_range(99) < stall_pct);
         bit other = $urandom_range(1);
         if (st) begin sdq_empty = blk; ldq_full = other; end
         else    begin ldq_full = blk;  sdq_empty = other; end
         if (inject && !injected && k > 0) begin
            injected = 1;
            req_valid = 1; req_base = ~b; req_pitch = p + 32'h40; req_rows_m1 = '0; req_store = ~st;
         end else req_valid = 0;
         #1;
         check(st ? "R7 store issue vs sdq_empty" : "R6 load issue vs ldq_full", mem_valid, !blk);
         check("R5 busy during block", busy, 1);
         if (mem_valid) begin
            check(k == 0 ? "R3 first address" : "R4 row address", mem_addr, exp_addr(b, p, k));
            check("R7 write direction", mem_write, st);
            check("R8 byte enables", mem_be, exp_be(w_m1));
            k++;
         end
         @(negedge clk);
         guard++;
      end
      req_valid = 0; ldq_full = 0; sdq_empty = 0;
      #1;
      check("R5 rows issued", k, rows_m1 + 1);
      check("R9 done pulse", done, 1);
      check("R9 busy low with done", busy, 0);
      check("R9 ready again", req_ready, 1);
      check("R5 no extra row", mem_valid, 0);
      @(negedge clk); #1;
      check("R9 done one cycle", done, 0);
   endtask

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      #1;
      check("R1 busy reset", busy, 0);
      check("R1 done reset", done, 0);
      check("R1 valid reset", mem_valid, 0);
      check("R1 ready reset", req_ready, 1);
      rst_n = 1;
      // directed corners
      run_block(0, 32'h1000, 32'h20, 0, 0, 0, 0);          // single row, width 1
      run_block(1, 32'h2000, 32'h10, 0, 3, 50, 0);         // single row store, full width
      run_block(0, 32'h10, 32'h0, 5, 1, 30, 0);            // zero pitch
      run_block(1, 32'h100, 32'hFFFF_FFF0, 20, 2, 40, 1);  // downward wrap, rival request
      run_block(0, 32'hFFFF_FF00, 32'h40, 9, 3, 20, 1);    // address wrap past top
      run_block(0, 32'h8000_0000, 32'h80, 1023, 3, 10, 1); // maximum row count
      for (int n = 0; n < 30; n++)
         run_block($urandom_range(1), $urandom, $urandom & 32'h0000_FFFC,
                   $urandom_range(40), $urandom_range(3), $urandom_range(60), $urandom_range(1));
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles >= 150000);
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule